// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor that completes each instruction in one clock period. It supports the R-type operations add, sub, and, or and slt, plus word load, word store, branch-if-equal and an absolute jump. The program counter register, a 32-entry register file and the data-memory write port are the only state updated at the rising edge. Fetch, decode, register read, ALU, data-memory read and write-back selection are all combinational within the period. Instruction and data storage are two separate word-addressed arrays inside the block.

Decoding is done in two levels. The 6-bit opcode drives a main decoder that produces the datapath steering signals and a 2-bit ALU mode. The ALU mode is then combined with the function field to select the ALU operation. The next program counter is one of three values: the sequential address (PC+4), the branch target, or the jump target built from the upper PC bits.

The arrays are filled through a valid/ready load port before the program runs. The load port is ready only while reset is held. A word is taken on a rising edge where both valid and ready are high. While ready is low, a word that is offered is not taken, and the source must hold it until ready returns. A set of plain status pins shows each cycle's register write-back and data-memory store.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register except r0 is cleared. During reset, `rf_we` and `dm_we` stay low.
- R2: `ld_ready` is high exactly while `rst` is high. When `ld_valid` and `ld_ready` are both high at an edge, `ld_data` is written to word `ld_addr`. The target is data storage when `ld_dmem`=1 and instruction storage when `ld_dmem`=0. Words offered while `ld_ready` is low are not written.
- R3: An instruction that is not a branch or a jump advances the PC by 4. Instructions are fetched from the word indexed by PC bits [7:2].
- R4: Opcode 000000 is R-type. The fields are rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Funct 100000 gives add, 100010 gives sub, 100100 gives and, and 100101 gives or. The result is written to rd.
- R5: R-type funct 101010 writes 1 to rd when rs is less than rt as signed two's complement values, and writes 0 otherwise.
- R6: Opcode 100011 loads the data word at rs plus the sign-extended immediate [15:0] into rt.
- R7: Opcode 101011 stores rt to the data word at rs plus the sign-extended immediate. It performs no register write.
- R8: Opcode 000100 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, and the offset may be negative. Otherwise the next PC is PC+4. No write occurs in either case.
- R9: Opcode 000010 sets the PC to {PC+4 bits [31:28], instruction bits [25:0], 2'b00}. It performs no register or memory write.
- R10: Register 0 always reads as zero. A write that names register 0 is dropped, and `rf_we` stays low for it.
- R11: An unrecognised opcode is a no-op that writes nothing and advances the PC by 4. An R-type instruction with an unrecognised funct or a nonzero shamt [10:6] is treated the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also opens the load port |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be taken (high during reset) |
| ld_dmem | input | 1 | Load target: 1 data storage, 0 instruction storage |
| ld_addr | input | 6 | Load word index |
| ld_data | input | 32 | Load word value |
| pc | output | 32 | Address of the instruction executing this cycle |
| rf_we | output | 1 | A register write-back commits at the end of this cycle |
| rf_waddr | output | 5 | Destination register of that write-back |
| rf_wdata | output | 32 | Value written back |
| dm_we | output | 1 | A data store commits at the end of this cycle |
| dm_addr | output | 32 | Effective address / ALU result |
| dm_wdata | output | 32 | Store data (rt) |

## Verification
The program reads back a stored word and then runs a taken forward branch over two poisoned instructions. After that come a not-taken compare, an unknown opcode carrying an R-type-looking destination, a jump over three more poisoned words, and a backward branch that loops on itself. A wrong branch-offset scale, wrong sign extension, or a missed taken/not-taken decision shows up as a PC off the expected trace or as a write from a poisoned instruction. The program writes to r0 and later uses r0 as a source. If r0 were writable, the later sum would be 21 instead of 7. A load word is held on the port while the core runs. If the run-time gate were missing, the next load would return that word instead of the preloaded data. Finally, a reset in mid-run is followed by a reload of instruction word 0. Reading r1 after the reload shows whether reset really cleared the register file.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    MODE_ADD   = 2'b00,
    MODE_SUB   = 2'b01,
    MODE_FUNCT = 2'b10
  } alu_mode_e;

  typedef enum logic [2:0] {
    FN_SEL_AND,
    FN_SEL_OR,
    FN_SEL_ADD,
    FN_SEL_SUB,
    FN_SEL_SLT
  } alu_fn_e;

  typedef struct packed {
    logic      reg_we;
    logic      use_imm;
    logic      wb_from_mem;
    logic      dst_is_rd;
    logic      mem_rd;
    logic      mem_we;
    logic      is_branch;
    logic      is_jump;
    alu_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{default: '0, mode: MODE_ADD};
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.reg_we    = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        ctrl.mode      = MODE_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.reg_we      = 1'b1;
        ctrl.use_imm     = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.mem_rd      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.mode      = MODE_SUB;
      end
      OPC_JUMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  alu_mode_e  mode,
  input  logic [5:0] funct,
  output alu_fn_e    fn,
  output logic       fn_ok
);
  always_comb begin
    fn    = FN_SEL_ADD;
    fn_ok = 1'b1;
    unique case (mode)
      MODE_SUB: fn = FN_SEL_SUB;
      MODE_FUNCT: begin
        unique case (funct)
          FN_ADD:  fn = FN_SEL_ADD;
          FN_SUB:  fn = FN_SEL_SUB;
          FN_AND:  fn = FN_SEL_AND;
          FN_OR:   fn = FN_SEL_OR;
          FN_SLT:  fn = FN_SEL_SLT;
          default: fn_ok = 1'b0;
        endcase
      end
      default: fn = FN_SEL_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      FN_SEL_AND: y = a & b;
      FN_SEL_OR:  y = a | b;
      FN_SEL_SUB: y = a - b;
      FN_SEL_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default:    y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                            regs[g] <= '0;
        else if (we && wa == AW'(g))        regs[g] <= wd;
      end
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW  = $clog2(IMEM_WORDS),
  localparam int DAW  = $clog2(DMEM_WORDS),
  localparam int LDAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic            ld_dmem,
  input  logic [LDAW-1:0] ld_addr,
  input  logic [31:0]     ld_data,
  output logic [31:0]     pc,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [31:0]     rf_wdata,
  output logic            dm_we,
  output logic [31:0]     dm_addr,
  output logic [31:0]     dm_wdata
);
  logic [31:0] imem_q [IMEM_WORDS];
  logic [31:0] dmem_q [DMEM_WORDS];
  logic [31:0] pc_q, instr, pc_plus4, br_target, j_target, pc_next;
  logic [31:0] rs_val, rt_val, imm_ext, alu_b, alu_y, dm_rdata;
  logic        alu_zero, fn_ok, wr_allowed, ld_take;
  logic [4:0]  dst;
  ctrl_t       ctrl;
  alu_fn_e     fn;

  assign ld_ready = rst;
  assign ld_take  = ld_valid && ld_ready;

  // fetch
  assign instr = imem_q[pc_q[IAW+1:2]];

  sc_main_dec u_dec (.opcode(instr[31:26]), .ctrl(ctrl));

  sc_alu_ctrl u_actl (.mode(ctrl.mode), .funct(instr[5:0]), .fn(fn), .fn_ok(fn_ok));

  sc_regfile #(.W(32), .NREG(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(instr[25:21]), .ra2(instr[20:16]),
    .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(dst), .wd(rf_wdata)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(.W(32)) u_alu (.a(rs_val), .b(alu_b), .fn(fn), .y(alu_y), .zero(alu_zero));

  assign dm_rdata = ctrl.mem_rd ? dmem_q[alu_y[DAW+1:2]] : '0;

  // write-back and store commit
  assign wr_allowed = (ctrl.mode != MODE_FUNCT) || (fn_ok && instr[10:6] == 5'd0);
  assign dst        = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign rf_waddr   = dst;
  assign rf_wdata   = ctrl.wb_from_mem ? dm_rdata : alu_y;
  assign rf_we      = ctrl.reg_we && wr_allowed && !rst && (dst != 5'd0);
  assign dm_we      = ctrl.mem_we && !rst;
  assign dm_addr    = alu_y;
  assign dm_wdata   = rt_val;

  // next PC
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  always_comb begin
    if (ctrl.is_jump)                    pc_next = j_target;
    else if (ctrl.is_branch && alu_zero) pc_next = br_target;
    else                                 pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end
  assign pc = pc_q;

  always_ff @(posedge clk) begin
    if (ld_take && !ld_dmem) imem_q[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_take && ld_dmem)  dmem_q[ld_addr[DAW-1:0]] <= ld_data;
    else if (dm_we)          dmem_q[alu_y[DAW+1:2]]   <= rt_val;
  end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        dm_we,
  input logic [5:0]  opcode,
  input logic [15:0] imm
);
  AST_PC_CLEARED: assert property (@(posedge clk) rst |=> pc == 32'd0); // R1
  AST_QUIET_IN_RESET: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we)); // R1
  AST_PC_WORD: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00); // R3
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_BEQ && opcode != OPC_JUMP) |=> pc == $past(pc) + 32'd4); // R3
  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (rst) dm_we |-> !rf_we); // R7
  AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (rst)
    opcode == OPC_BEQ |=> (pc == $past(pc) + 32'd4 ||
      pc == $past(pc) + 32'd4 + {{14{$past(imm[15])}}, $past(imm), 2'b00})); // R8
  AST_JUMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    opcode == OPC_JUMP |-> (!rf_we && !dm_we)); // R9
  AST_R0_NEVER: assert property (@(posedge clk) disable iff (rst) rf_we |-> rf_waddr != 5'd0); // R10
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .rf_we(rf_we), .rf_waddr(rf_waddr),
  .dm_we(dm_we), .opcode(instr[31:26]), .imm(instr[15:0])
);

// File: tb/test_sc_core.sv
`timescale 1ns/100ps
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        ld_ready, rf_we, dm_we;
  logic [4:0]  rf_waddr;
  logic [31:0] pc, rf_wdata, dm_addr, dm_wdata;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_dmem(ld_dmem), .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  localparam int NPROG = 22;
  localparam logic [31:0] PROG [NPROG] = '{
    32'h8C010000, 32'h8C020004, 32'h00221820, 32'h00222022, // 00..0C
    32'h00222824, 32'h00223025, 32'h0041382A, 32'h0022402A, // 10..1C
    32'h00210020, 32'hAC83FFFC, 32'h8C090008, 32'h11230002, // 20..2C
    32'h00215020, 32'h00215020, 32'h10220005, 32'hFC0C6020, // 30..3C
    32'h08000014, 32'h00215020, 32'h00215020, 32'h00215020, // 40..4C
    32'h00015820, 32'h1000FFFF                              // 50..54
  };

  // {pc, rf_we, rf_waddr, rf_wdata, dm_we, dm_addr, dm_wdata}
  localparam int NV = 18;
  localparam logic [134:0] VEC [NV] = '{
    {32'h00, 1'b1, 5'd1,  32'h00000007, 1'b0, 64'h0},
    {32'h04, 1'b1, 5'd2,  32'hFFFFFFFB, 1'b0, 64'h0},
    {32'h08, 1'b1, 5'd3,  32'h00000002, 1'b0, 64'h0},
    {32'h0C, 1'b1, 5'd4,  32'h0000000C, 1'b0, 64'h0},
    {32'h10, 1'b1, 5'd5,  32'h00000003, 1'b0, 64'h0},
    {32'h14, 1'b1, 5'd6,  32'hFFFFFFFF, 1'b0, 64'h0},
    {32'h18, 1'b1, 5'd7,  32'h00000001, 1'b0, 64'h0},
    {32'h1C, 1'b1, 5'd8,  32'h00000000, 1'b0, 64'h0},
    {32'h20, 1'b0, 5'd0,  32'h0,        1'b0, 64'h0},
    {32'h24, 1'b0, 5'd0,  32'h0,        1'b1, 32'h8, 32'h2},
    {32'h28, 1'b1, 5'd9,  32'h00000002, 1'b0, 64'h0},
    {32'h2C, 1'b0, 5'd0,  32'h0,        1'b0, 64'h0},
    {32'h38, 1'b0, 5'd0,  32'h0,        1'b0, 64'h0},
    {32'h3C, 1'b0, 5'd0,  32'h0,        1'b0, 64'h0},
    {32'h40, 1'b0, 5'd0,  32'h0,        1'b0, 64'h0},
    {32'h50, 1'b1, 5'd11, 32'h00000007, 1'b0, 64'h0},
    {32'h54, 1'b0, 5'd0,  32'h0,        1'b0, 64'h0},
    {32'h54, 1'b0, 5'd0,  32'h0,        1'b0, 64'h0}
  };

  function automatic string tag(input int i);
    case (i)
      0, 10:        return "R6";
      1:            return "R2/R6 load port gated while running";
      2, 3, 4, 5:   return "R4";
      6, 7:         return "R5";
      8, 15:        return "R10";
      9:            return "R7";
      11, 12, 16, 17: return "R8";
      13:           return "R11";
      default:      return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", pc, 32'h0);
    chk("R1", "rf_we in reset", {31'd0, rf_we}, 32'h0);
    chk("R1", "dm_we in reset", {31'd0, dm_we}, 32'h0);
    chk("R2", "ld_ready in reset", {31'd0, ld_ready}, 32'h1);

    for (int i = 0; i < NPROG; i++) begin
      @(posedge clk); #1;
      ld_valid = 1'b1; ld_dmem = 1'b0; ld_addr = 6'(i); ld_data = PROG[i];
    end
    @(posedge clk); #1;
    ld_dmem = 1'b1; ld_addr = 6'd0; ld_data = 32'h00000007;
    @(posedge clk); #1;
    ld_addr = 6'd1; ld_data = 32'hFFFFFFFB;
    @(posedge clk); #1;
    // keep a word on the port while the core runs: it must not be taken (R2)
    ld_addr = 6'd1; ld_data = 32'h00000099;
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i == 0) chk("R2", "ld_ready while running", {31'd0, ld_ready}, 32'h0);
      chk(tag(i), "pc", pc, VEC[i][134:103]);
      chk(tag(i), "rf_we", {31'd0, rf_we}, {31'd0, VEC[i][102]});
      if (VEC[i][102]) begin
        chk(tag(i), "rf_waddr", {27'd0, rf_waddr}, {27'd0, VEC[i][101:97]});
        chk(tag(i), "rf_wdata", rf_wdata, VEC[i][96:65]);
      end
      chk(tag(i), "dm_we", {31'd0, dm_we}, {31'd0, VEC[i][64]});
      if (VEC[i][64]) begin
        chk(tag(i), "dm_addr", dm_addr, VEC[i][63:32]);
        chk(tag(i), "dm_wdata", dm_wdata, VEC[i][31:0]);
      end
      if (i == 0) begin
        @(posedge clk); #1;
        ld_valid = 1'b0;
      end
    end

    // directed: reset in mid-run
    @(posedge clk); #1;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "no write while reset asserted", {30'd0, rf_we, dm_we}, 32'h0);
    chk("R2", "ld_ready follows reset", {31'd0, ld_ready}, 32'h1);
    @(negedge clk);
    chk("R1", "pc cleared by reset", pc, 32'h0);
    // reload instruction word 0 with add r12, r0, r1
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_dmem = 1'b0; ld_addr = 6'd0; ld_data = 32'h00016020;
    @(posedge clk); #1;
    ld_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R2", "reloaded word executes", {27'd0, rf_waddr}, 32'd12);
    chk("R1", "r1 cleared by reset", rf_wdata, 32'h0);
    chk("R1", "rf_we after release", {31'd0, rf_we}, 32'h1);
    @(negedge clk);
    chk("R3", "pc steps by 4", pc, 32'h4);
    chk("R6", "preloaded data kept", rf_wdata, 32'hFFFFFFFB);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule